// File: doc/BRIEF.md
# Two-Way Lockable Data Cache with Virtual Index and Physical Tag

The block is a two-way set-associative data cache sitting between a load/store pipeline and a simple doubleword memory port. The set is selected from virtual-address bits, and the physical tag arrives in the same cycle from the translation unit running in parallel. The tag compare therefore happens without a separate translation stage. Each access carries a page attribute that chooses write-back or write-through for that store. Two lock inputs pin either way so that replacement never takes it.

A miss that allocates first writes back a dirty victim and then fills the 32-byte line in four 64-bit beats. The fill starts at the requested doubleword and wraps around the line. A load is released in the cycle its own doubleword arrives, while the rest of the fill continues in the background. When both ways are locked, a miss goes straight to memory as a single uncached beat and nothing is allocated. The requester holds its request until `cpu_done` is seen.

Top module: `vipt_dcache`

## Requirements
- R1: After reset every line is invalid, no memory request is raised, and the first access to any address misses.
- R2: The set is `req_vindex[9:2]` and the doubleword is `req_vindex[1:0]`. An access hits when that set holds a valid line whose tag equals `req_ptag` of the same cycle, and a load hit raises `cpu_done` with its data in the cycle it is presented.
- R3: A store hit under the write-back attribute (`req_wt`=0) completes in the cycle it is presented. It updates only the cache, marks the line dirty, and makes no memory request.
- R4: A dirty victim is written to memory as four write beats, doublewords 0 to 3 of its line, before the fill starts. A clean victim causes no write beat.
- R5: A load miss fills its line starting at the requested doubleword in wrap order (w, w+1, w+2, w+3 modulo 4). `cpu_done` rises, with that doubleword on `cpu_rdata`, in the cycle the first fill beat is acknowledged, and the remaining beats follow on the memory port.
- R6: A store under the write-through attribute (`req_wt`=1) makes exactly one memory write beat. On a hit it also updates the cached copy. On a miss it does not allocate a line.
- R7: A store miss under the write-back attribute allocates the line, fills it, and then merges the store so that a later load of that doubleword hits with the stored value.
- R8: The victim is the least recently used way of the set among the unlocked ways (`lock_way[n]`=1 locks way n), and a locked way is never replaced.
- R9: With both ways locked, a miss is serviced by one uncached memory beat, a read or a write as requested, and no line is allocated.
- R10: `mem_addr` is a doubleword address made of {physical tag, set, doubleword}. A raised `mem_req` keeps its address and direction until `mem_ack`, and each acknowledgement completes one beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access presented; held until cpu_done |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wt | input | 1 | Page attribute: 1 = write-through, 0 = write-back |
| req_vindex | input | 10 | Virtual set index and doubleword select |
| req_ptag | input | 19 | Physical tag from translation, same cycle |
| req_wdata | input | 64 | Store data |
| lock_way | input | 2 | Per-way replacement lock |
| cpu_done | output | 1 | Access completes this cycle |
| cpu_stall | output | 1 | Access presented but not yet complete |
| cpu_rdata | output | 64 | Load data, valid with cpu_done |
| mem_req | output | 1 | Memory beat requested |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 29 | Doubleword address of the beat |
| mem_wdata | output | 64 | Write beat data |
| mem_ack | input | 1 | Beat accepted; read data valid |
| mem_rdata | input | 64 | Read beat data |

## Verification
The bound checker watches, on every cycle, that a memory beat keeps its address until acknowledged and that no allocation picks a locked way or happens with both ways locked. It also checks that load hits and write-back store hits finish in the cycle they are presented with no memory traffic, and that a load is released on its first fill beat. Only the bench's scenarios can show the data that comes back and the LRU choice over a sequence. They also show the wrap order and count of fill beats, that dirty data reaches memory on eviction, and that a write-through miss or an uncached access leaves nothing allocated.

// File: rtl/dc_pkg.sv
package dc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WB,
    ST_FILL,
    ST_WT,
    ST_UNC
  } dc_state_e;

  // Replacement choice: a locked way is never returned while the other is free.
  function automatic logic pick_victim(input logic [1:0] lock, input logic lru_way);
    if (lock[0]) return 1'b1;
    if (lock[1]) return 1'b0;
    return lru_way;
  endfunction

  // Least recently used way after touching way 'mru'.
  function automatic logic lru_after(input logic mru);
    return ~mru;
  endfunction

endpackage

// File: rtl/dc_tags.sv
module dc_tags #(
  parameter int SETS  = 256,
  parameter int IDX_W = 8,
  parameter int TAG_W = 19
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [IDX_W-1:0]      look_set,
  input  logic [TAG_W-1:0]      look_tag,
  output logic [1:0]            hit,
  output logic [1:0]            vld,
  output logic [1:0]            dty,
  output logic [1:0][TAG_W-1:0] tags,
  output logic                  lru_way,
  input  logic                  fill_we,
  input  logic [IDX_W-1:0]      fill_set,
  input  logic                  fill_way,
  input  logic [TAG_W-1:0]      fill_tag,
  input  logic                  dirty_we,
  input  logic [IDX_W-1:0]      dirty_set,
  input  logic                  dirty_way,
  input  logic                  lru_we,
  input  logic [IDX_W-1:0]      lru_set,
  input  logic                  lru_mru
);

  logic [SETS-1:0] lru_q;

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [SETS-1:0]  v_q;
    logic [SETS-1:0]  d_q;
    logic [TAG_W-1:0] t_q [SETS];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q <= '0;
        d_q <= '0;
      end else begin
        if (fill_we && fill_way == w[0]) begin
          v_q[fill_set] <= 1'b1;
          d_q[fill_set] <= 1'b0;
        end
        if (dirty_we && dirty_way == w[0]) d_q[dirty_set] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (fill_we && fill_way == w[0]) t_q[fill_set] <= fill_tag;
    end

    assign vld[w]  = v_q[look_set];
    assign dty[w]  = d_q[look_set];
    assign tags[w] = t_q[look_set];
    assign hit[w]  = v_q[look_set] && (t_q[look_set] == look_tag);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lru_q <= '0;
    else if (lru_we) lru_q[lru_set] <= dc_pkg::lru_after(lru_mru);
  end

  assign lru_way = lru_q[look_set];

endmodule

// File: rtl/dc_data.sv
module dc_data #(
  parameter int SETS  = 256,
  parameter int IDX_W = 8,
  parameter int WORDS = 4,
  parameter int WRD_W = 2,
  parameter int DW    = 64
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] rd_set,
  input  logic             rd_way,
  input  logic [WRD_W-1:0] rd_word,
  output logic [DW-1:0]    rd_data,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_set,
  input  logic             wr_way,
  input  logic [WRD_W-1:0] wr_word,
  input  logic [DW-1:0]    wr_data
);

  localparam int DEPTH = 2 * SETS * WORDS;
  localparam int A_W   = 1 + IDX_W + WRD_W;

  logic [DW-1:0] mem_q [DEPTH];
  logic [A_W-1:0] ra, wa;

  assign ra = {rd_way, rd_set, rd_word};
  assign wa = {wr_way, wr_set, wr_word};
  assign rd_data = mem_q[ra];

  always_ff @(posedge clk) begin
    if (we) mem_q[wa] <= wr_data;
  end

endmodule

// File: rtl/dc_ctrl.sv
module dc_ctrl #(
  parameter int IDX_W = 8,
  parameter int WRD_W = 2,
  parameter int WORDS = 4,
  parameter int TAG_W = 19,
  parameter int DW    = 64,
  localparam int MA_W = TAG_W + IDX_W + WRD_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic                  req_wt,
  input  logic [IDX_W-1:0]      req_set,
  input  logic [WRD_W-1:0]      req_word,
  input  logic [TAG_W-1:0]      req_tag,
  input  logic [DW-1:0]         req_wdata,
  input  logic [1:0]            lock,
  input  logic [1:0]            hit,
  input  logic [1:0]            vld,
  input  logic [1:0]            dty,
  input  logic [1:0][TAG_W-1:0] tags,
  input  logic                  lru_way,
  input  logic [DW-1:0]         line_rdata,
  input  logic                  mem_ack,
  input  logic [DW-1:0]         mem_rdata,
  output logic                  done,
  output logic                  rd_from_mem,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [MA_W-1:0]       mem_addr,
  output logic [DW-1:0]         mem_wdata,
  output logic [IDX_W-1:0]      rd_set,
  output logic                  rd_way,
  output logic [WRD_W-1:0]      rd_word,
  output logic                  dat_we,
  output logic [IDX_W-1:0]      wr_set,
  output logic                  wr_way,
  output logic [WRD_W-1:0]      wr_word,
  output logic [DW-1:0]         wr_data,
  output logic                  fill_we,
  output logic [IDX_W-1:0]      fill_set,
  output logic                  fill_way,
  output logic [TAG_W-1:0]      fill_tag,
  output logic                  dirty_we,
  output logic                  lru_we,
  output logic [IDX_W-1:0]      lru_set,
  output logic                  lru_mru,
  output logic                  ev_hit,
  output logic                  ev_alloc,
  output logic                  vic_way,
  output logic                  ev_fill_first,
  output logic                  fill_is_read,
  output logic                  st_idle
);
  import dc_pkg::*;

  dc_state_e        st_q, st_d;
  logic [IDX_W-1:0] set_q;
  logic             way_q;
  logic [TAG_W-1:0] ftag_q, wtag_q;
  logic [WRD_W-1:0] crit_q, beat_q, beat_d, fill_word;
  logic             rd_q;
  logic             hway, vdirty, last_beat;

  assign ev_hit        = |hit;
  assign hway          = hit[1];
  assign vic_way       = pick_victim(lock, lru_way);
  assign vdirty        = vld[vic_way] & dty[vic_way];
  assign last_beat     = (beat_q == WRD_W'(WORDS - 1));
  assign fill_word     = crit_q + beat_q;
  assign st_idle       = (st_q == ST_IDLE);
  assign ev_fill_first = (st_q == ST_FILL) && (beat_q == '0);
  assign fill_is_read  = rd_q;
  assign fill_set      = set_q;
  assign fill_way      = way_q;
  assign fill_tag      = ftag_q;

  always_comb begin
    st_d        = st_q;
    beat_d      = beat_q;
    done        = 1'b0;
    rd_from_mem = 1'b0;
    mem_req     = 1'b0;
    mem_we      = 1'b0;
    mem_addr    = {req_tag, req_set, req_word};
    mem_wdata   = req_wdata;
    rd_set      = req_set;
    rd_way      = hway;
    rd_word     = req_word;
    dat_we      = 1'b0;
    wr_set      = req_set;
    wr_way      = hway;
    wr_word     = req_word;
    wr_data     = req_wdata;
    fill_we     = 1'b0;
    dirty_we    = 1'b0;
    lru_we      = 1'b0;
    lru_set     = req_set;
    lru_mru     = hway;
    ev_alloc    = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_valid) begin
        if (ev_hit) begin
          if (!req_write) begin
            done   = 1'b1;
            lru_we = 1'b1;
          end else if (!req_wt) begin
            done     = 1'b1;
            dat_we   = 1'b1;
            dirty_we = 1'b1;
            lru_we   = 1'b1;
          end else begin
            st_d = ST_WT;
          end
        end else if (&lock) begin
          st_d = ST_UNC;
        end else if (req_write && req_wt) begin
          st_d = ST_WT;
        end else begin
          ev_alloc = 1'b1;
          beat_d   = '0;
          st_d     = vdirty ? ST_WB : ST_FILL;
        end
      end
      ST_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {wtag_q, set_q, beat_q};
        rd_set    = set_q;
        rd_way    = way_q;
        rd_word   = beat_q;
        mem_wdata = line_rdata;
        if (mem_ack) begin
          beat_d = beat_q + WRD_W'(1);
          if (last_beat) st_d = ST_FILL;
        end
      end
      ST_FILL: begin
        mem_req  = 1'b1;
        mem_addr = {ftag_q, set_q, fill_word};
        if (mem_ack) begin
          dat_we  = 1'b1;
          wr_set  = set_q;
          wr_way  = way_q;
          wr_word = fill_word;
          wr_data = mem_rdata;
          beat_d  = beat_q + WRD_W'(1);
          if (beat_q == '0 && rd_q) begin
            done        = 1'b1;
            rd_from_mem = 1'b1;
          end
          if (last_beat) begin
            fill_we = 1'b1;
            lru_we  = 1'b1;
            lru_set = set_q;
            lru_mru = way_q;
            st_d    = ST_IDLE;
          end
        end
      end
      ST_WT: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ack) begin
          done = 1'b1;
          st_d = ST_IDLE;
          if (ev_hit) begin
            dat_we = 1'b1;
            lru_we = 1'b1;
          end
        end
      end
      ST_UNC: begin
        mem_req = 1'b1;
        mem_we  = req_write;
        if (mem_ack) begin
          done        = 1'b1;
          rd_from_mem = !req_write;
          st_d        = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      beat_q <= '0;
      set_q  <= '0;
      way_q  <= 1'b0;
      ftag_q <= '0;
      wtag_q <= '0;
      crit_q <= '0;
      rd_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      beat_q <= beat_d;
      if (ev_alloc) begin
        set_q  <= req_set;
        way_q  <= vic_way;
        ftag_q <= req_tag;
        wtag_q <= tags[vic_way];
        crit_q <= req_word;
        rd_q   <= !req_write;
      end
    end
  end

endmodule

// File: rtl/vipt_dcache.sv
module vipt_dcache #(
  parameter int CACHE_BYTES = 16384,
  parameter int LINE_BYTES  = 32,
  parameter int DW          = 64,
  parameter int TAG_W       = 19,
  localparam int WORDS = LINE_BYTES * 8 / DW,
  localparam int WRD_W = $clog2(WORDS),
  localparam int SETS  = CACHE_BYTES / (2 * LINE_BYTES),
  localparam int IDX_W = $clog2(SETS),
  localparam int VI_W  = IDX_W + WRD_W,
  localparam int MA_W  = TAG_W + VI_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic            req_wt,
  input  logic [VI_W-1:0] req_vindex,
  input  logic [TAG_W-1:0] req_ptag,
  input  logic [DW-1:0]   req_wdata,
  input  logic [1:0]      lock_way,
  output logic            cpu_done,
  output logic            cpu_stall,
  output logic [DW-1:0]   cpu_rdata,
  output logic            mem_req,
  output logic            mem_we,
  output logic [MA_W-1:0] mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic            mem_ack,
  input  logic [DW-1:0]   mem_rdata
);

  logic [IDX_W-1:0]      req_set;
  logic [WRD_W-1:0]      req_word;
  logic [1:0]            hit, vld, dty;
  logic [1:0][TAG_W-1:0] tags;
  logic                  lru_way;
  logic [DW-1:0]         line_rdata;
  logic                  rd_from_mem;
  logic [IDX_W-1:0]      rd_set, wr_set, fill_set, lru_set;
  logic                  rd_way, wr_way, fill_way, lru_mru;
  logic [WRD_W-1:0]      rd_word, wr_word;
  logic                  dat_we, fill_we, dirty_we, lru_we;
  logic [DW-1:0]         wr_data;
  logic [TAG_W-1:0]      fill_tag;
  // Named events for the bound checker.
  logic                  ev_hit, ev_alloc, vic_way, ev_fill_first, fill_is_read, st_idle;

  assign req_set   = req_vindex[VI_W-1:WRD_W];
  assign req_word  = req_vindex[WRD_W-1:0];
  assign cpu_rdata = rd_from_mem ? mem_rdata : line_rdata;
  assign cpu_stall = req_valid & ~cpu_done;

  dc_tags #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .look_set(req_set), .look_tag(req_ptag),
    .hit(hit), .vld(vld), .dty(dty), .tags(tags), .lru_way(lru_way),
    .fill_we(fill_we), .fill_set(fill_set), .fill_way(fill_way), .fill_tag(fill_tag),
    .dirty_we(dirty_we), .dirty_set(req_set), .dirty_way(hit[1]),
    .lru_we(lru_we), .lru_set(lru_set), .lru_mru(lru_mru)
  );

  dc_data #(.SETS(SETS), .IDX_W(IDX_W), .WORDS(WORDS), .WRD_W(WRD_W), .DW(DW)) u_data (
    .clk(clk),
    .rd_set(rd_set), .rd_way(rd_way), .rd_word(rd_word), .rd_data(line_rdata),
    .we(dat_we), .wr_set(wr_set), .wr_way(wr_way), .wr_word(wr_word), .wr_data(wr_data)
  );

  dc_ctrl #(.IDX_W(IDX_W), .WRD_W(WRD_W), .WORDS(WORDS), .TAG_W(TAG_W), .DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_wt(req_wt),
    .req_set(req_set), .req_word(req_word), .req_tag(req_ptag), .req_wdata(req_wdata),
    .lock(lock_way), .hit(hit), .vld(vld), .dty(dty), .tags(tags), .lru_way(lru_way),
    .line_rdata(line_rdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .done(cpu_done), .rd_from_mem(rd_from_mem),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .rd_set(rd_set), .rd_way(rd_way), .rd_word(rd_word),
    .dat_we(dat_we), .wr_set(wr_set), .wr_way(wr_way), .wr_word(wr_word), .wr_data(wr_data),
    .fill_we(fill_we), .fill_set(fill_set), .fill_way(fill_way), .fill_tag(fill_tag),
    .dirty_we(dirty_we), .lru_we(lru_we), .lru_set(lru_set), .lru_mru(lru_mru),
    .ev_hit(ev_hit), .ev_alloc(ev_alloc), .vic_way(vic_way),
    .ev_fill_first(ev_fill_first), .fill_is_read(fill_is_read), .st_idle(st_idle)
  );

endmodule

// File: rtl/vipt_dcache_chk.sv
module vipt_dcache_chk #(
  parameter int MA_W = 29
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_write,
  input logic            req_wt,
  input logic [1:0]      lock_way,
  input logic            cpu_done,
  input logic            mem_req,
  input logic            mem_we,
  input logic            mem_ack,
  input logic [MA_W-1:0] mem_addr,
  input logic            ev_hit,
  input logic            ev_alloc,
  input logic            vic_way,
  input logic            ev_fill_first,
  input logic            fill_is_read,
  input logic            st_idle
);

  assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  assert_victim_unlocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_alloc |-> !lock_way[vic_way]);

  assert_locked_no_alloc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_alloc |-> !(lock_way[0] && lock_way[1]));

  assert_hit_load_now_R2: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle && req_valid && ev_hit && !req_write |-> cpu_done);

  assert_done_has_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> req_valid);

  assert_wb_hit_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle && req_valid && ev_hit && req_write && !req_wt |-> cpu_done && !mem_req);

  assert_first_beat_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill_first && mem_ack && fill_is_read |-> cpu_done);

endmodule

bind vipt_dcache vipt_dcache_chk #(.MA_W(MA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write), .req_wt(req_wt),
  .lock_way(lock_way), .cpu_done(cpu_done), .mem_req(mem_req), .mem_we(mem_we),
  .mem_ack(mem_ack), .mem_addr(mem_addr), .ev_hit(ev_hit), .ev_alloc(ev_alloc),
  .vic_way(vic_way), .ev_fill_first(ev_fill_first), .fill_is_read(fill_is_read),
  .st_idle(st_idle)
);

// File: tb/tb_vipt_dcache.sv
module tb_vipt_dcache;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_wt = 1'b0;
  logic [9:0]  req_vindex = '0;
  logic [18:0] req_ptag = '0;
  logic [63:0] req_wdata = '0;
  logic [1:0]  lock_way = 2'b00;
  logic        cpu_done, cpu_stall, mem_req, mem_we;
  logic [63:0] cpu_rdata, mem_wdata;
  logic [28:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [63:0] mem_rdata = '0;

  int n_chk = 0, n_fail = 0, n_rd = 0, n_wr = 0;
  logic [63:0] model  [4096];
  logic [63:0] golden [4096];
  logic [1:0]  rd_log [4];

  always #5 clk = ~clk;

  vipt_dcache dut (.*);

  function automatic logic [63:0] seed_val(input int a);
    return {16'hA5C3, 16'(a), 32'(a * 32'h9E37_79B9)};
  endfunction

  // Memory: one beat per request, acknowledged in the following cycle.
  always @(posedge clk) begin
    if (mem_req && mem_ack) begin
      if (mem_we) begin
        model[mem_addr[11:0]] <= mem_wdata;
        n_wr <= n_wr + 1;
      end else begin
        rd_log[n_rd[1:0]] <= mem_addr[1:0];
        n_rd <= n_rd + 1;
      end
    end
    mem_ack   <= mem_req & ~mem_ack;
    mem_rdata <= model[mem_addr[11:0]];
  end

  task automatic check(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic access(input bit wr, input bit wt, input logic [2:0] tag, input logic [7:0] idx,
                        input logic [1:0] word, input logic [63:0] wd,
                        output logic [63:0] rd, output int cyc, output bit mreq);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_wt = wt;
    req_ptag = 19'(tag); req_vindex = {idx, word}; req_wdata = wd;
    #1;
    cyc = 0;
    while (!cpu_done && cyc < 300) begin
      @(negedge clk); #1;
      cyc++;
    end
    rd = cpu_rdata;
    mreq = mem_req;
    if (wr) golden[{tag[1:0], idx, word}] = wd;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (mem_req) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  // [15]=store [14]=write-through [13]=zero-wait expected [12:10]=tag [9:2]=set [1:0]=doubleword
  localparam logic [15:0] VEC [15] = '{
    {1'b0, 1'b0, 1'b0, 3'd0, 8'd5,  2'd2},
    {1'b0, 1'b0, 1'b1, 3'd0, 8'd5,  2'd0},
    {1'b1, 1'b0, 1'b1, 3'd0, 8'd5,  2'd1},
    {1'b0, 1'b0, 1'b1, 3'd0, 8'd5,  2'd1},
    {1'b0, 1'b0, 1'b0, 3'd1, 8'd5,  2'd3},
    {1'b0, 1'b0, 1'b1, 3'd0, 8'd5,  2'd1},
    {1'b0, 1'b0, 1'b0, 3'd2, 8'd5,  2'd0},
    {1'b0, 1'b0, 1'b0, 3'd1, 8'd5,  2'd0},
    {1'b0, 1'b0, 1'b0, 3'd0, 8'd5,  2'd1},
    {1'b1, 1'b1, 1'b0, 3'd0, 8'd5,  2'd2},
    {1'b0, 1'b0, 1'b1, 3'd0, 8'd5,  2'd2},
    {1'b1, 1'b1, 1'b0, 3'd3, 8'd9,  2'd0},
    {1'b0, 1'b0, 1'b0, 3'd3, 8'd9,  2'd0},
    {1'b1, 1'b0, 1'b0, 3'd2, 8'd12, 2'd3},
    {1'b0, 1'b0, 1'b1, 3'd2, 8'd12, 2'd3}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung actual=%0d expected=0", 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] rd, wd;
    int cyc, w0, r0;
    bit mreq;
    for (int a = 0; a < 4096; a++) begin
      model[a]  = seed_val(a);
      golden[a] = seed_val(a);
    end
    do_reset();

    // R1: reset state
    @(negedge clk);
    check(!mem_req && !cpu_done && !cpu_stall, "R1 reset idle", {61'd0, mem_req, cpu_done, cpu_stall}, 64'd0);

    // Vector table: R1 R2 R3 R4 R6 R7 R8 over one set plus two others
    for (int i = 0; i < 15; i++) begin
      logic [15:0] v;
      v  = VEC[i];
      wd = 64'hD00D_0000_0000_0000 | 64'(i);
      access(v[15], v[14], v[12:10], v[9:2], v[1:0], wd, rd, cyc, mreq);
      check((cyc == 0) == v[13], $sformatf("R2/R8 vector %0d wait", i), 64'(cyc), {63'd0, !v[13]});
      if (!v[15])
        check(rd == golden[{v[11:10], v[9:2], v[1:0]}], $sformatf("R7 vector %0d data", i),
              rd, golden[{v[11:10], v[9:2], v[1:0]}]);
      wait_idle();
    end
    // R6: write-through hit reached memory
    check(model[{2'd0, 8'd5, 2'd2}] == golden[{2'd0, 8'd5, 2'd2}], "R6 wt hit memory",
          model[{2'd0, 8'd5, 2'd2}], golden[{2'd0, 8'd5, 2'd2}]);

    // R5: critical doubleword first, early release, wrap order
    r0 = n_rd;
    access(1'b0, 1'b0, 3'd0, 8'd30, 2'd2, '0, rd, cyc, mreq);
    check(cyc == 2, "R5 release on first beat", 64'(cyc), 64'd2);
    check(mreq, "R5 fill continues after release", {63'd0, mreq}, 64'd1);
    check(rd == golden[{2'd0, 8'd30, 2'd2}], "R5 critical data", rd, golden[{2'd0, 8'd30, 2'd2}]);
    wait_idle();
    check(n_rd - r0 == 4, "R5 beat count", 64'(n_rd - r0), 64'd4);
    check({rd_log[r0[1:0]], rd_log[2'(r0 + 1)], rd_log[2'(r0 + 2)], rd_log[2'(r0 + 3)]} == 8'b10_11_00_01,
          "R5 wrap order", {56'd0, rd_log[r0[1:0]], rd_log[2'(r0 + 1)], rd_log[2'(r0 + 2)], rd_log[2'(r0 + 3)]},
          64'h00000000000000b1);

    // R3: write-back store hit stays in the cache
    w0 = n_wr;
    access(1'b1, 1'b0, 3'd0, 8'd30, 2'd0, 64'hBEEF_0000_0000_0030, rd, cyc, mreq);
    repeat (4) @(negedge clk);
    check(n_wr == w0 && cyc == 0, "R3 no memory write", 64'(n_wr - w0), 64'd0);
    check(model[{2'd0, 8'd30, 2'd0}] == seed_val({2'd0, 8'd30, 2'd0}), "R3 memory untouched",
          model[{2'd0, 8'd30, 2'd0}], seed_val({2'd0, 8'd30, 2'd0}));

    // R4: dirty victim written back as four beats, clean victim not at all
    access(1'b0, 1'b0, 3'd1, 8'd30, 2'd0, '0, rd, cyc, mreq);
    wait_idle();
    w0 = n_wr;
    access(1'b0, 1'b0, 3'd2, 8'd30, 2'd1, '0, rd, cyc, mreq);
    wait_idle();
    check(n_wr - w0 == 4, "R4 dirty writeback beats", 64'(n_wr - w0), 64'd4);
    check(model[{2'd0, 8'd30, 2'd0}] == 64'hBEEF_0000_0000_0030, "R4 dirty data in memory",
          model[{2'd0, 8'd30, 2'd0}], 64'hBEEF_0000_0000_0030);
    w0 = n_wr;
    access(1'b0, 1'b0, 3'd3, 8'd30, 2'd1, '0, rd, cyc, mreq);
    wait_idle();
    check(n_wr == w0, "R4 clean victim silent", 64'(n_wr - w0), 64'd0);

    // R8: a locked way survives
    access(1'b0, 1'b0, 3'd0, 8'd40, 2'd0, '0, rd, cyc, mreq); wait_idle();
    access(1'b0, 1'b0, 3'd1, 8'd40, 2'd0, '0, rd, cyc, mreq); wait_idle();
    lock_way = 2'b01;
    access(1'b0, 1'b0, 3'd2, 8'd40, 2'd0, '0, rd, cyc, mreq); wait_idle();
    access(1'b0, 1'b0, 3'd0, 8'd40, 2'd3, '0, rd, cyc, mreq);
    check(cyc == 0, "R8 locked way kept", 64'(cyc), 64'd0);
    access(1'b0, 1'b0, 3'd1, 8'd40, 2'd0, '0, rd, cyc, mreq); wait_idle();
    check(cyc != 0, "R8 unlocked way replaced", 64'(cyc), 64'd2);

    // R9: both locked, uncached single beats, no allocation
    lock_way = 2'b11;
    r0 = n_rd;
    access(1'b0, 1'b0, 3'd3, 8'd40, 2'd2, '0, rd, cyc, mreq); wait_idle();
    check(n_rd - r0 == 1, "R9 one uncached read beat", 64'(n_rd - r0), 64'd1);
    check(rd == golden[{2'd3, 8'd40, 2'd2}], "R9 uncached data", rd, golden[{2'd3, 8'd40, 2'd2}]);
    access(1'b0, 1'b0, 3'd3, 8'd40, 2'd2, '0, rd, cyc, mreq); wait_idle();
    check(cyc != 0, "R9 no allocation", 64'(cyc), 64'd2);
    w0 = n_wr;
    access(1'b1, 1'b0, 3'd3, 8'd40, 2'd1, 64'h0DD0_0000_0000_0040, rd, cyc, mreq); wait_idle();
    check(n_wr - w0 == 1 && model[{2'd3, 8'd40, 2'd1}] == 64'h0DD0_0000_0000_0040,
          "R9 uncached write", model[{2'd3, 8'd40, 2'd1}], 64'h0DD0_0000_0000_0040);
    access(1'b0, 1'b0, 3'd0, 8'd40, 2'd1, '0, rd, cyc, mreq);
    check(cyc == 0 && rd == golden[{2'd0, 8'd40, 2'd1}], "R8 both locked lines still hit", 64'(cyc), 64'd0);
    lock_way = 2'b00;

    // R1: reset invalidates cached lines
    wait_idle();
    do_reset();
    access(1'b0, 1'b0, 3'd0, 8'd5, 2'd2, '0, rd, cyc, mreq);
    check(cyc != 0, "R1 miss after reset", 64'(cyc), 64'd2);
    wait_idle();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule